// File: doc/BRIEF.md
# Sized Integer ALU Stage with Destination Merge and Masked Flags

This block is the execute stage of a micro-op engine. Each valid request carries an operation, a first operand, a second operand (a register value or an 8-bit immediate), the old value of the destination register, an operation width in bytes, a flag-select mask and, for the conditional move, a condition code. One clock edge after the request, the stage presents the new destination value and the updated flag register, together with an output valid strobe.

The result never overwrites the whole destination. Only the low bytes covered by the operation width take the new value, and the upper bytes keep the old destination contents. The flag register lives inside the block. Add-with-carry and subtract-with-borrow read its CF bit, and the conditional move tests it. Each request then rewrites only the flag bits that its select mask names.

Decode, the register file and writeback arbitration are outside this block. The caller supplies the old destination value and consumes the merged result.

Top module: `szalu_stage`

## Requirements
- R1: `res_vld` is high in exactly the cycle after a cycle with `req_vld` high. When `req_vld` is low, `res_data` and `flags` hold their values.
- R2: `width_sel` gives the operation width in bytes: 1, 2, 4 or 8. Any other code is treated as 8. Only the low `width_sel` bytes of `res_data` come from the operation. The upper bytes equal `dst_old`.
- R3: With `imm_sel`=1 the second operand is `imm` zero-extended to 64 bits, and `src_b` has no effect. With `imm_sel`=0 the second operand is `src_b`.
- R4: Operation codes are 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 AND, 5 OR, 6 XOR and 7 CMOV. ADD gives a+b. ADC gives a+b+CF, using the stored CF.
- R5: SUB gives a-b. SBB gives a-b-CF. Both are formed as a + ~b + carry-in, with carry-in 1 for SUB and NOT CF for SBB. CF and AF report a borrow, meaning the inverted carry.
- R6: AND, OR and XOR give the bitwise result. For these three operations, CF, OF and AF are written as 0 when they are selected.
- R7: The flag register layout is bit0 CF, bit1 PF, bit2 AF, bit3 ZF, bit4 SF and bit5 OF. `flag_sel` uses the same bit positions. A flag bit whose select bit is 0 keeps its old value.
- R8: ZF, SF, CF and OF are evaluated at the operation width.
  - ZF is set when the sized result is zero.
  - SF is the top bit of the sized result.
  - CF comes from the carry out of that top bit.
  - OF is the carry into the top bit XOR the carry out of it.
  - PF is 1 when the low 8 result bits hold an even number of ones.
  - AF comes from the carry out of bit 3.
- R9: CMOV writes the second operand, merged at the operation width, only when its condition is true. Otherwise `res_data` equals `dst_old`. CMOV never changes the flags.
  - `cond[3:1]` selects the test: 0 true, 1 CF, 2 ZF, 3 SF, 4 OF, 5 PF, 6 CF|ZF, 7 SF^OF.
  - `cond[0]` inverts the test.
- R10: After reset, `res_vld`, `res_data` and `flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| imm_sel | input | 1 | Select immediate as second operand |
| width_sel | input | 4 | Operation width in bytes |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand (register form) |
| imm | input | 8 | Immediate (zero-extended) |
| dst_old | input | 64 | Previous destination value |
| flag_sel | input | 6 | Flags to rewrite |
| cond | input | 4 | Condition code for CMOV |
| res_vld | output | 1 | Result valid |
| res_data | output | 64 | Merged destination value |
| flags | output | 6 | Flag register |

## Verification
Result data, flags and `res_vld` are all due at the first rising edge after the request cycle. The bench drives a request on a falling edge and samples all three on the next falling edge, which lies half a period after that rising edge. Add-with-carry, subtract-with-borrow and conditional move depend on the flag state left by the previous request. Those checks therefore run as short chains, where each step's expected flags are derived from the step before it. Idle cycles are sampled on falling edges to confirm that the outputs hold.

// File: rtl/szalu_pkg.sv
package szalu_pkg;
   localparam int FLAG_W = 6;
   localparam int F_CF = 0;
   localparam int F_PF = 1;
   localparam int F_AF = 2;
   localparam int F_ZF = 3;
   localparam int F_SF = 4;
   localparam int F_OF = 5;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_ADC  = 3'd1,
      OP_SUB  = 3'd2,
      OP_SBB  = 3'd3,
      OP_AND  = 3'd4,
      OP_OR   = 3'd5,
      OP_XOR  = 3'd6,
      OP_CMOV = 3'd7
   } alu_op_e;
endpackage

// File: rtl/szalu_lanes.sv
module szalu_lanes #(
   parameter int DATA_W = 64,
   localparam int NBYTES = DATA_W / 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic [3:0]        width_sel,
   output logic [DATA_W-1:0] lane_mask,
   output logic [IDX_W-1:0]  top_bit
);
   localparam int CNT_W = $clog2(NBYTES) + 1;

   if (DATA_W != 64) begin : g_bad_width
      $error("szalu_lanes: DATA_W must be 64");
   end

   logic [CNT_W-1:0] nbytes;

   always_comb begin
      case (width_sel)
         4'd1:    nbytes = CNT_W'(1);
         4'd2:    nbytes = CNT_W'(2);
         4'd4:    nbytes = CNT_W'(4);
         default: nbytes = CNT_W'(NBYTES);
      endcase
   end

   for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      assign lane_mask[g*8 +: 8] = {8{CNT_W'(g) < nbytes}};
   end

   assign top_bit = IDX_W'((32'(nbytes) * 8) - 1);
endmodule

// File: rtl/szalu_cond.sv
module szalu_cond
   import szalu_pkg::*;
(
   input  logic [FLAG_W-1:0] cur_flags,
   input  logic [3:0]        cond,
   output logic              take
);
   logic raw;

   always_comb begin
      case (cond[3:1])
         3'd0: raw = 1'b1;
         3'd1: raw = cur_flags[F_CF];
         3'd2: raw = cur_flags[F_ZF];
         3'd3: raw = cur_flags[F_SF];
         3'd4: raw = cur_flags[F_OF];
         3'd5: raw = cur_flags[F_PF];
         3'd6: raw = cur_flags[F_CF] | cur_flags[F_ZF];
         default: raw = cur_flags[F_SF] ^ cur_flags[F_OF];
      endcase
   end

   assign take = raw ^ cond[0];
endmodule

// File: rtl/szalu_core.sv
module szalu_core
   import szalu_pkg::*;
#(
   parameter int DATA_W = 64,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [DATA_W-1:0] dst_old,
   input  logic [DATA_W-1:0] lane_mask,
   input  logic [IDX_W-1:0]  top_bit,
   input  logic              cf_in,
   input  logic              take,
   output logic [DATA_W-1:0] merged,
   output logic [FLAG_W-1:0] new_flags,
   output logic              flag_wen
);
   logic              is_sub;
   logic              is_logic;
   logic [DATA_W-1:0] b_eff;
   logic              cin;
   logic [DATA_W:0]   sum;
   logic [DATA_W:0]   cv;
   logic [IDX_W:0]    out_pos;
   logic              c_out;
   logic              c_top;
   logic [DATA_W-1:0] raw;

   assign is_sub   = (op == OP_SUB) || (op == OP_SBB);
   assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
   assign b_eff    = is_sub ? ~opb : opb;

   always_comb begin
      case (op)
         OP_ADC:  cin = cf_in;
         OP_SUB:  cin = 1'b1;
         OP_SBB:  cin = ~cf_in;
         default: cin = 1'b0;
      endcase
   end

   assign sum     = {1'b0, opa} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
   assign cv      = {sum[DATA_W], opa ^ b_eff ^ sum[DATA_W-1:0]};
   assign out_pos = {1'b0, top_bit} + (IDX_W+1)'(1);
   assign c_out   = cv[out_pos];
   assign c_top   = cv[{1'b0, top_bit}];

   always_comb begin
      case (op)
         OP_AND:  raw = opa & opb;
         OP_OR:   raw = opa | opb;
         OP_XOR:  raw = opa ^ opb;
         OP_CMOV: raw = opb;
         default: raw = sum[DATA_W-1:0];
      endcase
   end

   always_comb begin
      if (op == OP_CMOV && !take)
         merged = dst_old;
      else
         merged = (dst_old & ~lane_mask) | (raw & lane_mask);
   end

   always_comb begin
      new_flags        = '0;
      new_flags[F_ZF]  = ((raw & lane_mask) == '0);
      new_flags[F_SF]  = raw[top_bit];
      new_flags[F_PF]  = ~^raw[7:0];
      if (!is_logic) begin
         new_flags[F_CF] = c_out ^ is_sub;
         new_flags[F_AF] = cv[4] ^ is_sub;
         new_flags[F_OF] = c_top ^ c_out;
      end
   end

   assign flag_wen = (op != OP_CMOV);
endmodule

// File: rtl/szalu_stage.sv
module szalu_stage
   import szalu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int IMM_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic [2:0]        op,
   input  logic              imm_sel,
   input  logic [3:0]        width_sel,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [IMM_W-1:0]  imm,
   input  logic [DATA_W-1:0] dst_old,
   input  logic [5:0]        flag_sel,
   input  logic [3:0]        cond,
   output logic              res_vld,
   output logic [DATA_W-1:0] res_data,
   output logic [5:0]        flags
);
   localparam int IDX_W = $clog2(DATA_W);

   if (IMM_W > DATA_W) begin : g_bad_imm
      $error("szalu_stage: IMM_W wider than DATA_W");
   end

   logic [DATA_W-1:0] lane_mask;
   logic [IDX_W-1:0]  top_bit;
   logic [DATA_W-1:0] opb;
   logic              take;
   logic [DATA_W-1:0] merged;
   logic [FLAG_W-1:0] new_flags;
   logic              flag_wen;
   logic [FLAG_W-1:0] flags_q;
   logic [DATA_W-1:0] res_q;
   logic              vld_q;

   assign opb = imm_sel ? {{(DATA_W-IMM_W){1'b0}}, imm} : src_b;

   szalu_lanes #(.DATA_W(DATA_W)) u_lanes (
      .width_sel (width_sel),
      .lane_mask (lane_mask),
      .top_bit   (top_bit)
   );

   szalu_cond u_cond (
      .cur_flags (flags_q),
      .cond      (cond),
      .take      (take)
   );

   szalu_core #(.DATA_W(DATA_W)) u_core (
      .op        (alu_op_e'(op)),
      .opa       (src_a),
      .opb       (opb),
      .dst_old   (dst_old),
      .lane_mask (lane_mask),
      .top_bit   (top_bit),
      .cf_in     (flags_q[F_CF]),
      .take      (take),
      .merged    (merged),
      .new_flags (new_flags),
      .flag_wen  (flag_wen)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         res_q   <= '0;
         flags_q <= '0;
      end else begin
         vld_q <= req_vld;
         if (req_vld) begin
            res_q <= merged;
            if (flag_wen)
               flags_q <= (flag_sel & new_flags) | (~flag_sel & flags_q);
         end
      end
   end

   assign res_vld  = vld_q;
   assign res_data = res_q;
   assign flags    = flags_q;
endmodule

// File: rtl/szalu_checker.sv
module szalu_checker
   import szalu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_vld,
   input logic [2:0]        op,
   input logic [3:0]        width_sel,
   input logic [DATA_W-1:0] dst_old,
   input logic [5:0]        flag_sel,
   input logic              res_vld,
   input logic [DATA_W-1:0] res_data,
   input logic [5:0]        flags
);
   assert_vld_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> res_vld);

   assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> (!res_vld && $stable(res_data) && $stable(flags)));

   assert_byte_merge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && width_sel == 4'd1) |=> (res_data[DATA_W-1:8] == $past(dst_old[DATA_W-1:8])));

   assert_half_merge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && width_sel == 4'd4) |=> (res_data[DATA_W-1:32] == $past(dst_old[DATA_W-1:32])));

   assert_unselected_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> (((flags ^ $past(flags)) & ~$past(flag_sel)) == 6'd0));

   assert_logic_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && (op == OP_AND || op == OP_OR || op == OP_XOR) && flag_sel[F_CF])
      |=> !flags[F_CF]);

   assert_cmov_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && op == OP_CMOV) |=> $stable(flags));
endmodule

bind szalu_stage szalu_checker #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_vld   (req_vld),
   .op        (op),
   .width_sel (width_sel),
   .dst_old   (dst_old),
   .flag_sel  (flag_sel),
   .res_vld   (res_vld),
   .res_data  (res_data),
   .flags     (flags)
);

// File: tb/sim_szalu_stage.sv
module sim_szalu_stage;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 10;

   typedef struct packed {
      logic [2:0]  op;
      logic        isel;
      logic [3:0]  wsel;
      logic [63:0] a;
      logic [63:0] b;
      logic [7:0]  im;
      logic [63:0] dold;
      logic [63:0] eres;
      logic [5:0]  eflg;
   } vec_t;

   localparam vec_t TBL [NVEC] = '{
      '{3'd0, 1'b0, 4'd1, 64'h1111_1111_1111_117F, 64'h1, 8'h00, 64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AA80, 6'h34},
      '{3'd0, 1'b1, 4'd2, 64'h0000_0000_0000_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'h01, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_0000, 6'h0F},
      '{3'd2, 1'b0, 4'd4, 64'hFFFF_FFFF_0000_0005, 64'h7, 8'h00, 64'hDEAD_BEEF_0000_0000, 64'hDEAD_BEEF_FFFF_FFFE, 6'h15},
      '{3'd2, 1'b0, 4'd8, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 8'h00, 64'h5555_5555_5555_5555, 64'h0, 6'h0A},
      '{3'd2, 1'b0, 4'd1, 64'h80, 64'h1, 8'h00, 64'hFFFF_FFFF_FFFF_FF00, 64'hFFFF_FFFF_FFFF_FF7F, 6'h24},
      '{3'd4, 1'b0, 4'd8, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 8'h00, 64'h0, 64'hF000_F000_F000_F000, 6'h12},
      '{3'd5, 1'b1, 4'd2, 64'h8000, 64'hFFFF, 8'h03, 64'hCCCC_CCCC_CCCC_CCCC, 64'hCCCC_CCCC_CCCC_8003, 6'h12},
      '{3'd6, 1'b0, 4'd4, 64'h1234_5678, 64'h1234_5678, 8'h00, 64'h7777_7777_7777_7777, 64'h7777_7777_0000_0000, 6'h0A},
      '{3'd0, 1'b0, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 8'h00, 64'h1234, 64'h0, 6'h0F},
      '{3'd0, 1'b0, 4'd8, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 8'h00, 64'h0, 64'h8000_0000_0000_0000, 6'h36}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0;
   logic [2:0]  op = '0;
   logic        imm_sel = 1'b0;
   logic [3:0]  width_sel = 4'd8;
   logic [63:0] src_a = '0;
   logic [63:0] src_b = '0;
   logic [7:0]  imm = '0;
   logic [63:0] dst_old = '0;
   logic [5:0]  flag_sel = '0;
   logic [3:0]  cond = '0;
   logic        res_vld;
   logic [63:0] res_data;
   logic [5:0]  flags;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   szalu_stage u0 (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .op(op), .imm_sel(imm_sel),
      .width_sel(width_sel), .src_a(src_a), .src_b(src_b), .imm(imm),
      .dst_old(dst_old), .flag_sel(flag_sel), .cond(cond),
      .res_vld(res_vld), .res_data(res_data), .flags(flags)
   );

   task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] o, input logic is, input logic [3:0] w,
                        input logic [63:0] a, input logic [63:0] b, input logic [7:0] im,
                        input logic [63:0] d, input logic [5:0] fs, input logic [3:0] cc);
      @(negedge clk);
      req_vld = 1'b1; op = o; imm_sel = is; width_sel = w; src_a = a; src_b = b;
      imm = im; dst_old = d; flag_sel = fs; cond = cc;
      @(negedge clk);
      req_vld = 1'b0;
      chk64("R1 res_vld after request", {63'd0, res_vld}, 64'd1);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk64("R10 res_vld at reset", {63'd0, res_vld}, 64'd0);
      chk64("R10 res_data at reset", res_data, 64'd0);
      chk64("R10 flags at reset", {58'd0, flags}, 64'd0);
      rst_n = 1'b1;

      // R2 R3 R4 R5 R6 R8: vector table with all flags selected
      for (int i = 0; i < NVEC; i++) begin
         issue(TBL[i].op, TBL[i].isel, TBL[i].wsel, TBL[i].a, TBL[i].b, TBL[i].im,
               TBL[i].dold, 6'h3F, 4'd0);
         chk64($sformatf("R2 R4 R5 R6 vector %0d result", i), res_data, TBL[i].eres);
         chk64($sformatf("R8 vector %0d flags", i), {58'd0, flags}, {58'd0, TBL[i].eflg});
      end

      // R4 ADC uses CF: set CF with 0xFF+1 at byte width
      issue(3'd0, 1'b0, 4'd1, 64'hFF, 64'h1, 8'h0, 64'h0, 6'h3F, 4'd0);
      chk64("R4 carry setup CF", {63'd0, flags[0]}, 64'd1);
      issue(3'd1, 1'b0, 4'd1, 64'h10, 64'h20, 8'h0, 64'h0, 6'h3F, 4'd0);
      chk64("R4 ADC result", res_data, 64'h31);
      chk64("R4 ADC flags", {58'd0, flags}, 64'h0);

      // R5 SBB uses CF: 0-1 sets borrow, then 0x10-1-1
      issue(3'd2, 1'b0, 4'd1, 64'h0, 64'h1, 8'h0, 64'h0, 6'h3F, 4'd0);
      chk64("R5 borrow setup flags", {58'd0, flags}, 64'h17);
      issue(3'd3, 1'b0, 4'd1, 64'h10, 64'h1, 8'h0, 64'h0, 6'h3F, 4'd0);
      chk64("R5 SBB result", res_data, 64'h0E);
      chk64("R5 SBB CF", {63'd0, flags[0]}, 64'd0);

      // R7 flag mask: restore 0x17 then update ZF only
      issue(3'd2, 1'b0, 4'd1, 64'h0, 64'h1, 8'h0, 64'h0, 6'h3F, 4'd0);
      issue(3'd0, 1'b0, 4'd1, 64'h0, 64'h0, 8'h0, 64'h0, 6'h08, 4'd0);
      chk64("R7 only ZF rewritten", {58'd0, flags}, 64'h1F);

      // R6 logic op clears selected CF and OF, others kept
      issue(3'd4, 1'b0, 4'd8, 64'hFF, 64'hFF, 8'h0, 64'h0, 6'h21, 4'd0);
      chk64("R6 logic clears CF/OF", {58'd0, flags}, 64'h1E);

      // R9 CMOV on ZF (true), flags 0x1E untouched even with all selected
      issue(3'd7, 1'b0, 4'd2, 64'h0, 64'hABCD, 8'h0, 64'h1111_1111_1111_1111, 6'h3F, 4'b0100);
      chk64("R9 CMOV taken result", res_data, 64'h1111_1111_1111_ABCD);
      chk64("R9 CMOV keeps flags", {58'd0, flags}, 64'h1E);
      issue(3'd7, 1'b0, 4'd8, 64'h0, 64'hABCD, 8'h0, 64'h2222_3333_4444_5555, 6'h3F, 4'b0010);
      chk64("R9 CMOV not taken result", res_data, 64'h2222_3333_4444_5555);
      // R3 immediate with inverted CF test (CF=0 so true)
      issue(3'd7, 1'b1, 4'd1, 64'h0, 64'hFFFF_FFFF, 8'h5A, 64'h9999_9999_9999_9999, 6'h3F, 4'b0011);
      chk64("R3 R9 CMOV immediate", res_data, 64'h9999_9999_9999_995A);

      // R1 idle: outputs hold with no request
      repeat (3) @(negedge clk);
      chk64("R1 idle res_vld low", {63'd0, res_vld}, 64'd0);
      chk64("R1 idle res_data held", res_data, 64'h9999_9999_9999_995A);
      chk64("R1 idle flags held", {58'd0, flags}, 64'h1E);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule